// File: doc/BRIEF.md
# ADC Sample Trigger and Pending Scheduler

This block sits in front of a single analog-to-digital converter and arbitrates sixteen sample slots. Each slot is configured with a trigger source, a delay prescaler code and a delay count. When the selected trigger fires, the slot either becomes pending at once or first counts out its delay and then becomes pending. A slot stays pending until the converter reports that its conversion has finished.

A sequencer picks one pending slot at a time and offers it to the converter over a valid/ready request channel. Once the request is offered, `conv_valid` and `conv_slot` do not change until `conv_ready` accepts them, and the sequencer never withdraws a request. After a handshake the converter is busy until it pulses `conv_done`. The block then clears that slot's pending bit and emits a one-cycle end-of-conversion strobe that carries the slot index. If a trigger arrives for a slot that is still delaying or pending, the trigger is dropped and the slot's sticky overrun flag is set. Software clears those flags by writing ones.

The delay configuration of a slot must stay constant while that slot is counting out its delay.

Top module: `adc_slot_sched`

## Requirements
- R1: After reset, `pending`, `ovf`, `ovf_any`, `conv_valid`, `busy` and `eoc` are all 0.
- R2: The 4-bit source code of slot i selects its trigger. Code 0 is software: the slot triggers when `sw_trig_we` is 1 and `sw_trig_mask[i]` is 1. Code k (1 to 15) triggers the slot on `hw_trig[k-1]`. Pulses on any other source have no effect on the slot.
- R3: A pending bit, once set, stays 1 until the edge at which `conv_done` completes that slot's conversion. It clears on that edge.
- R4: When the sequencer is idle and any slot is pending, it raises `conv_valid` with `conv_slot` equal to the lowest-numbered pending slot. The slot and the valid bit stay unchanged until `conv_ready` is sampled 1.
- R5: With delay count D and prescaler code c, where c = 0, 1, 2, 3 divides by 1, 2, 4, 16 (N), a trigger sampled at edge k sets the pending bit at edge k+D·N. With D = 0 the pending bit is set at edge k.
- R6: A trigger for a slot that is delaying or pending sets that slot's `ovf` bit and starts no further delay or conversion.
- R7: Writing `ovf_clr_we` clears every `ovf` bit whose `ovf_clr_mask` bit is 1. A new overrun in the same cycle wins over the clear. `ovf_any` is 1 exactly when any `ovf` bit is 1.
- R8: `busy` is 1 from the edge after the request handshake until the edge at which `conv_done` is sampled. On that edge, `eoc` pulses for one cycle and `eoc_slot` holds the slot that was converted.
- R9: A `conv_done` pulse while `busy` is 0 has no effect: no pending bit clears and `eoc` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_trig_we | input | 1 | Software trigger write strobe |
| sw_trig_mask | input | 16 | Slots to trigger by software |
| hw_trig | input | 15 | Hardware trigger pulses, sources 1 to 15 |
| cfg_src | input | 64 | Per-slot 4-bit source code, slot i at bits [4i+3:4i] |
| cfg_div | input | 32 | Per-slot 2-bit prescaler code, slot i at bits [2i+1:2i] |
| cfg_dly | input | 128 | Per-slot 8-bit delay count, slot i at bits [8i+7:8i] |
| ovf_clr_we | input | 1 | Overrun clear strobe |
| ovf_clr_mask | input | 16 | Overrun bits to clear (write 1) |
| conv_valid | output | 1 | Conversion request valid |
| conv_ready | input | 1 | Converter accepts the request |
| conv_slot | output | 4 | Slot of the conversion request |
| conv_done | input | 1 | Converter finished the current conversion |
| busy | output | 1 | A conversion is in progress |
| eoc | output | 1 | End-of-conversion strobe |
| eoc_slot | output | 4 | Slot whose conversion ended |
| pending | output | 16 | Per-slot pending bits |
| ovf | output | 16 | Per-slot event-overrun flags |
| ovf_any | output | 1 | OR of all overrun flags |

## Verification
Directed patterns separate the source decode by firing a neighbouring hardware source, the wrong software bit, and then the correct one (R2). They also sweep every prescaler code at a fixed delay count, so that an error of one prescaler step or one edge shows up as a pending bit in the wrong cycle (R5). Further directed cases cover retriggers, a clear that coincides with a new overrun, and a stray done pulse; these separate the sticky overrun logic from the ignore paths. Random phases use fixed-seed triggers spread across all sources, along with random ready and done timing. A requirement-level model checks the pending vector, flags, request, busy and end-of-conversion strobe every cycle. These phases exercise the lowest-first pick under contention and back-pressure on the request channel.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_PEND = 2'd2
  } slot_state_e;

  // prescaler terminal value for codes 0..3 -> divide by 1, 2, 4, 16
  function automatic logic [3:0] div_limit(input logic [1:0] code);
    case (code)
      2'd0:    div_limit = 4'd0;
      2'd1:    div_limit = 4'd1;
      2'd2:    div_limit = 4'd3;
      default: div_limit = 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/slot_unit.sv
module slot_unit
  import adc_sched_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             done_clr,
  input  logic             ovf_clr,
  input  logic [1:0]       div_code,
  input  logic [DLY_W-1:0] dly,
  output logic             pending,
  output logic             ovf
);

  slot_state_e      state_q;
  logic [3:0]       pre_q;
  logic [DLY_W-1:0] cnt_q;
  logic [3:0]       lim;

  assign lim     = div_limit(div_code);
  assign pending = (state_q == SLOT_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SLOT_IDLE: if (trig) begin
          if (dly == '0) state_q <= SLOT_PEND;
          else begin
            state_q <= SLOT_WAIT;
            cnt_q   <= dly;
            pre_q   <= '0;
          end
        end
        SLOT_WAIT: begin
          if (pre_q == lim) begin
            pre_q <= '0;
            if (cnt_q == DLY_W'(1)) state_q <= SLOT_PEND;
            else                    cnt_q   <= cnt_q - 1'b1;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        SLOT_PEND: if (done_clr) state_q <= SLOT_IDLE;
        default:   state_q <= SLOT_IDLE;
      endcase
    end
  end

  // sticky overrun: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ovf <= 1'b0;
    else if (trig && state_q != SLOT_IDLE) ovf <= 1'b1;
    else if (ovf_clr)                    ovf <= 1'b0;
  end

  p_retrig_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && state_q != SLOT_IDLE) |=> ovf);

  p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && done_clr) |=> !pending);

endmodule

// File: rtl/pick_lowest.sv
module pick_lowest #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] pending,
  output logic                 conv_valid,
  input  logic                 conv_ready,
  output logic [IDX_W-1:0]     conv_slot,
  input  logic                 conv_done,
  output logic                 busy,
  output logic [NUM_SLOTS-1:0] done_vec,
  output logic                 eoc,
  output logic [IDX_W-1:0]     eoc_slot
);

  logic             any_pend;
  logic [IDX_W-1:0] low_idx;
  logic [IDX_W-1:0] cur_q;

  pick_lowest #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .vec (pending),
    .any (any_pend),
    .idx (low_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_valid <= 1'b0;
      conv_slot  <= '0;
      busy       <= 1'b0;
      cur_q      <= '0;
    end else if (busy) begin
      if (conv_done) busy <= 1'b0;
    end else if (conv_valid) begin
      if (conv_ready) begin
        conv_valid <= 1'b0;
        busy       <= 1'b1;
        cur_q      <= conv_slot;
      end
    end else if (any_pend) begin
      conv_valid <= 1'b1;
      conv_slot  <= low_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc      <= 1'b0;
      eoc_slot <= '0;
    end else begin
      eoc <= busy && conv_done;
      if (busy && conv_done) eoc_slot <= cur_q;
    end
  end

  always_comb begin
    done_vec = '0;
    if (busy && conv_done) done_vec[cur_q] = 1'b1;
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !conv_ready) |=> (conv_valid && $stable(conv_slot)));

  p_eoc_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done) |=> (eoc && !busy));

  p_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && conv_done) |=> !eoc);

endmodule

// File: rtl/adc_slot_sched.sv
module adc_slot_sched #(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 4,
  parameter int DLY_W     = 8,
  localparam int NUM_SRC  = 1 << SRC_W,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_trig_we,
  input  logic [NUM_SLOTS-1:0]       sw_trig_mask,
  input  logic [NUM_SRC-2:0]         hw_trig,
  input  logic [NUM_SLOTS*SRC_W-1:0] cfg_src,
  input  logic [NUM_SLOTS*2-1:0]     cfg_div,
  input  logic [NUM_SLOTS*DLY_W-1:0] cfg_dly,
  input  logic                       ovf_clr_we,
  input  logic [NUM_SLOTS-1:0]       ovf_clr_mask,
  output logic                       conv_valid,
  input  logic                       conv_ready,
  output logic [IDX_W-1:0]           conv_slot,
  input  logic                       conv_done,
  output logic                       busy,
  output logic                       eoc,
  output logic [IDX_W-1:0]           eoc_slot,
  output logic [NUM_SLOTS-1:0]       pending,
  output logic [NUM_SLOTS-1:0]       ovf,
  output logic                       ovf_any
);

  logic [NUM_SLOTS-1:0] done_vec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [NUM_SRC-1:0] lines;
    logic               trig;

    // source 0 is the software bit, source k is hw_trig[k-1]
    assign lines = {hw_trig, sw_trig_we & sw_trig_mask[i]};
    assign trig  = lines[cfg_src[i*SRC_W +: SRC_W]];

    slot_unit #(.DLY_W(DLY_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig),
      .done_clr (done_vec[i]),
      .ovf_clr  (ovf_clr_we & ovf_clr_mask[i]),
      .div_code (cfg_div[i*2 +: 2]),
      .dly      (cfg_dly[i*DLY_W +: DLY_W]),
      .pending  (pending[i]),
      .ovf      (ovf[i])
    );
  end

  conv_seq #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pending    (pending),
    .conv_valid (conv_valid),
    .conv_ready (conv_ready),
    .conv_slot  (conv_slot),
    .conv_done  (conv_done),
    .busy       (busy),
    .done_vec   (done_vec),
    .eoc        (eoc),
    .eoc_slot   (eoc_slot)
  );

  assign ovf_any = |ovf;

  p_req_is_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> pending[conv_slot]);

  p_busy_slot_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> (busy || eoc));

endmodule

// File: tb/test_adc_slot_sched.sv
`timescale 1ns/1ps
module test_adc_slot_sched;

  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_trig_we = 1'b0;
  logic [15:0]   sw_trig_mask = '0;
  logic [14:0]   hw_trig = '0;
  logic [63:0]   cfg_src = '0;
  logic [31:0]   cfg_div = '0;
  logic [127:0]  cfg_dly = '0;
  logic          ovf_clr_we = 1'b0;
  logic [15:0]   ovf_clr_mask = '0;
  logic          conv_ready = 1'b0;
  logic          conv_done = 1'b0;
  logic          conv_valid, busy, eoc, ovf_any;
  logic [3:0]    conv_slot, eoc_slot;
  logic [15:0]   pending, ovf;

  int n_vec = 0;
  int n_bad = 0;

  // requirement-level model state
  logic [15:0] m_pend, m_wait, m_ovf;
  int          m_rem [NS];
  logic        m_reqv, m_busy, m_eoc;
  logic [3:0]  m_reqslot, m_cur, m_eoc_slot;

  adc_slot_sched i_adc_slot_sched (
    .clk(clk), .rst_n(rst_n), .sw_trig_we(sw_trig_we), .sw_trig_mask(sw_trig_mask),
    .hw_trig(hw_trig), .cfg_src(cfg_src), .cfg_div(cfg_div), .cfg_dly(cfg_dly),
    .ovf_clr_we(ovf_clr_we), .ovf_clr_mask(ovf_clr_mask), .conv_valid(conv_valid),
    .conv_ready(conv_ready), .conv_slot(conv_slot), .conv_done(conv_done), .busy(busy),
    .eoc(eoc), .eoc_slot(eoc_slot), .pending(pending), .ovf(ovf), .ovf_any(ovf_any)
  );

  always #2 clk = ~clk;

  function automatic int div_n(input logic [1:0] c);
    return (c == 2'd3) ? 16 : (1 << c);
  endfunction

  function automatic logic [3:0] lowest(input logic [15:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    n_vec++;
    if (pending !== m_pend) begin n_bad++; $display("FAIL R3 pending act=%0h exp=%0h", pending, m_pend); end
    if (ovf !== m_ovf) begin n_bad++; $display("FAIL R6 ovf act=%0h exp=%0h", ovf, m_ovf); end
    if (ovf_any !== (|m_ovf)) begin n_bad++; $display("FAIL R7 ovf_any act=%0h exp=%0h", ovf_any, |m_ovf); end
    if (conv_valid !== m_reqv) begin n_bad++; $display("FAIL R4 conv_valid act=%0h exp=%0h", conv_valid, m_reqv); end
    if (m_reqv && conv_slot !== m_reqslot) begin n_bad++; $display("FAIL R4 conv_slot act=%0h exp=%0h", conv_slot, m_reqslot); end
    if (busy !== m_busy) begin n_bad++; $display("FAIL R8 busy act=%0h exp=%0h", busy, m_busy); end
    if (eoc !== m_eoc) begin n_bad++; $display("FAIL R8 eoc act=%0h exp=%0h", eoc, m_eoc); end
    if (m_eoc && eoc_slot !== m_eoc_slot) begin n_bad++; $display("FAIL R8 eoc_slot act=%0h exp=%0h", eoc_slot, m_eoc_slot); end
  endtask

  task automatic model_reset();
    m_pend = '0; m_wait = '0; m_ovf = '0; m_reqv = 0; m_busy = 0; m_eoc = 0;
    m_reqslot = '0; m_cur = '0; m_eoc_slot = '0;
    for (int i = 0; i < NS; i++) m_rem[i] = 0;
  endtask

  task automatic model_step();
    logic [15:0] n_pend, n_wait, n_ovf;
    logic [15:0] lines;
    logic        trig, done_eff;
    int          dd, nn;
    n_pend = m_pend; n_wait = m_wait; n_ovf = m_ovf;
    done_eff = m_busy && conv_done;
    for (int i = 0; i < NS; i++) begin
      lines = {hw_trig, sw_trig_we & sw_trig_mask[i]};
      trig  = lines[cfg_src[i*4 +: 4]];
      if (trig && (m_pend[i] || m_wait[i])) n_ovf[i] = 1'b1;
      else if (ovf_clr_we && ovf_clr_mask[i]) n_ovf[i] = 1'b0;
      dd = int'(cfg_dly[i*8 +: 8]);
      nn = div_n(cfg_div[i*2 +: 2]);
      if (m_pend[i]) begin
        if (done_eff && m_cur == 4'(i)) n_pend[i] = 1'b0;
      end else if (m_wait[i]) begin
        m_rem[i]--;
        if (m_rem[i] == 0) begin n_wait[i] = 1'b0; n_pend[i] = 1'b1; end
      end else if (trig) begin
        if (dd == 0) n_pend[i] = 1'b1;
        else begin n_wait[i] = 1'b1; m_rem[i] = dd * nn; end
      end
    end
    m_eoc = done_eff;
    if (done_eff) m_eoc_slot = m_cur;
    if (m_busy) begin
      if (conv_done) m_busy = 1'b0;
    end else if (m_reqv) begin
      if (conv_ready) begin m_reqv = 1'b0; m_busy = 1'b1; m_cur = m_reqslot; end
    end else if (|m_pend) begin
      m_reqv = 1'b1; m_reqslot = lowest(m_pend);
    end
    m_pend = n_pend; m_wait = n_wait; m_ovf = n_ovf;
  endtask

  // inputs are set at the negedge, the model follows the posedge, outputs are compared at the next negedge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    sw_trig_we = 0; sw_trig_mask = '0; hw_trig = '0; conv_done = 0;
    ovf_clr_we = 0; ovf_clr_mask = '0;
  endtask

  task automatic drain();
    conv_ready = 1;
    for (int k = 0; k < 600; k++) begin
      if (m_pend == 0 && m_wait == 0 && !m_reqv && !m_busy && !m_eoc) break;
      conv_done = m_busy;
      tick();
    end
    conv_ready = 0;
  endtask

  task automatic set_slot(input int s, input int src, input int dv, input int dl);
    cfg_src[s*4 +: 4] = 4'(src);
    cfg_div[s*2 +: 2] = 2'(dv);
    cfg_dly[s*8 +: 8] = 8'(dl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pending == 0 && ovf == 0 && !ovf_any && !conv_valid && !busy && !eoc, "R1 reset",
        {pending, ovf}, 0);
    rst_n = 1;
    @(negedge clk);
    compare();

    // R2: source decode
    for (int s = 0; s < NS; s++) set_slot(s, 0, 0, 0);
    set_slot(3, 5, 0, 0);
    sw_trig_we = 1; sw_trig_mask = 16'h0009; tick();
    chk(pending == 16'h0001, "R2 software code0 only", pending, 16'h0001);
    hw_trig = 15'h0008; tick();   // source 4
    chk(pending[3] == 1'b0, "R2 neighbour source ignored", pending[3], 0);
    hw_trig = 15'h0010; tick();   // source 5
    chk(pending == 16'h0009, "R2 hw source 5", pending, 16'h0009);
    // R4: lowest slot offered first
    chk(conv_valid && conv_slot == 4'd0, "R4 lowest first", conv_slot, 0);
    repeat (3) tick();
    chk(conv_valid && conv_slot == 4'd0, "R4 held without ready", conv_slot, 0);
    drain();

    // R5: prescaler sweep, delay 3 on slot 1 from source 1
    for (int c = 0; c < 4; c++) begin
      set_slot(1, 1, c, 3);
      hw_trig = 15'h0001; tick();
      for (int k = 0; k < 3 * div_n(2'(c)) - 1; k++) tick();
      chk(pending[1] == 1'b0, "R5 not yet pending", pending[1], 0);
      tick();
      chk(pending[1] == 1'b1, "R5 pending on time", pending[1], 1);
      drain();
    end

    // R6, R7, R9 on slot 1 with no delay
    set_slot(1, 1, 0, 0);
    hw_trig = 15'h0001; tick();
    tick();
    conv_done = 1; tick();   // R9: stray done while idle converter
    chk(pending[1] == 1'b1 && !eoc, "R9 stray done ignored", pending[1], 1);
    hw_trig = 15'h0001; tick();
    chk(ovf[1] && ovf_any, "R6 retrigger sets overrun", ovf, 16'h0002);
    hw_trig = 15'h0001; ovf_clr_we = 1; ovf_clr_mask = 16'h0002; tick();
    chk(ovf[1] == 1'b1, "R7 set wins over clear", ovf[1], 1);
    ovf_clr_we = 1; ovf_clr_mask = 16'h0002; tick();
    chk(ovf == 0 && !ovf_any, "R7 write-1 clear", ovf, 0);
    conv_ready = 1; tick(); tick();
    chk(busy == 1'b1, "R8 busy after handshake", busy, 1);
    conv_done = 1; tick();
    chk(eoc && eoc_slot == 4'd1 && !pending[1], "R8 eoc carries slot", eoc_slot, 1);
    drain();

    // random phases checked by the model every cycle
    for (int r = 0; r < 6; r++) begin
      for (int s = 0; s < NS; s++) set_slot(s, $urandom_range(15), $urandom_range(3), $urandom_range(3));
      for (int k = 0; k < 500; k++) begin
        sw_trig_we = ($urandom_range(99) < 6);
        sw_trig_mask = 16'($urandom);
        for (int b = 0; b < 15; b++) hw_trig[b] = ($urandom_range(99) < 4);
        conv_ready = $urandom_range(1);
        conv_done = ($urandom_range(99) < 35);
        ovf_clr_we = ($urandom_range(99) < 5);
        ovf_clr_mask = 16'($urandom);
        tick();
      end
      drain();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule